// File: doc/BRIEF.md
# DMA Cutoff Window Guard

This block decides, for every DMA master request, whether the target address lies in a protected part of memory. Software writes one 12-bit control word. It holds three 4-bit cutoff counts. Each count grows a protected region downward from a fixed ceiling in fixed-size steps. A request that lands inside any protected region is refused with a fault. Every other request is granted in the same cycle it is presented.

Main memory covers 0x20000000 to 0x2FFFFFFF and is split into a lower half and an upper half at 0x28000000. The lower-half count measures its steps down from 0x28000000, but the region it protects runs all the way to the top of main memory. As a result, a non-zero lower count also shields the first 8 MiB of the upper half. The upper-half count measures down from 0x30000000. A separate count guards a secondary window that ends at 0x1F400000, with steps of 1 MiB.

Top module: `dmaCutoffGuard`

## Requirements
- R1: After reset the control word reads as zero and every valid request is granted.
- R2: A write updates the control word on the next clock edge. The read port then shows bits 11:0 of the written value, and bits 31:12 read as zero. Field layout: bits 3:0 hold the lower count, bits 7:4 the upper count, and bits 11:8 the secondary count.
- R3: With a non-zero lower count x, addresses from 0x28000000 − 0x800000·x up to 0x2FFFFFFF fault, and the address just below that range is granted.
- R4: A lower count of zero protects nothing by itself. In particular, 0x28000000–0x287FFFFF is granted unless some other count covers it.
- R5: Addresses 0x20000000–0x207FFFFF are never faulted, whatever the control word holds.
- R6: With upper count x, addresses from 0x30000000 − 0x800000·x up to 0x2FFFFFFF fault. A count of zero protects nothing.
- R7: When several counts are non-zero, the protected set is the union of their regions.
- R8: With secondary count x, addresses from 0x1F400000 − 0x100000·x up to 0x1F3FFFFF fault. Addresses from 0x1F400000 up to the start of main memory are granted.
- R9: In a cycle with a valid request, exactly one of grant and fault is high. In a cycle without a valid request, both are low. The outputs depend on the address in that same cycle only.
- R10: Addresses at or above 0x30000000 are always granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control word write strobe |
| cfgWrData | input | 32 | Control word write data |
| cfgRdData | output | 32 | Control word read data |
| reqValid | input | 1 | DMA request valid |
| reqAddr | input | 32 | DMA request byte address |
| reqGrant | output | 1 | Request allowed this cycle |
| reqFault | output | 1 | Request hit a protected address this cycle |

## Verification
The assertions assume that the request address and the write strobe are stable and known around each clock edge. They also assume that a write carries valid data, because the read-back property compares against the data sampled one cycle earlier. The stimulus changes inputs only on the falling edge and keeps every driven value defined. Random addresses are drawn mostly within a few steps of each region boundary, so both sides of every cutoff are exercised.

// File: rtl/dma_guard_pkg.sv
package dma_guard_pkg;
  localparam int ADDR_W = 32;
  localparam int CNT_W = 4;
  localparam int NUM_WIN = 3;
  localparam int CFG_W = CNT_W * NUM_WIN;

  typedef struct packed {
    logic [NUM_WIN-1:0] winOn;
    logic               checkReq;
  } guardStrobe_t;
endpackage

// File: rtl/guard_cfg_ctrl.sv
module guard_cfg_ctrl
  import dma_guard_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  reqValid,
  output logic [CFG_W-1:0]      cfgWord,
  output guardStrobe_t          strobe
);
  logic [CFG_W-1:0] cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (wrEn) cfgQ <= wrData[CFG_W-1:0];
  end

  always_comb begin
    rdData = '0;
    rdData[CFG_W-1:0] = cfgQ;
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_on
      assign strobe.winOn[w] = |cfgQ[w*CNT_W +: CNT_W];
    end
  endgenerate

  assign strobe.checkReq = reqValid;
  assign cfgWord = cfgQ;
endmodule

// File: rtl/guard_addr_path.sv
module guard_addr_path
  import dma_guard_pkg::*;
#(
  parameter logic [ADDR_W-1:0] MAIN_END  = 32'h3000_0000,
  parameter logic [ADDR_W-1:0] LOW_REF   = 32'h2800_0000,
  parameter logic [ADDR_W-1:0] MAIN_STEP = 32'h0080_0000,
  parameter logic [ADDR_W-1:0] SEC_END   = 32'h1F40_0000,
  parameter logic [ADDR_W-1:0] SEC_STEP  = 32'h0010_0000
) (
  input  logic [CFG_W-1:0]  cfgWord,
  input  guardStrobe_t      strobe,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] REF_TAB  [NUM_WIN] = '{LOW_REF, MAIN_END, SEC_END};
  localparam logic [ADDR_W-1:0] END_TAB  [NUM_WIN] = '{MAIN_END, MAIN_END, SEC_END};
  localparam logic [ADDR_W-1:0] STEP_TAB [NUM_WIN] = '{MAIN_STEP, MAIN_STEP, SEC_STEP};

  logic [NUM_WIN-1:0] winHit;

  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : g_win
      logic [CNT_W-1:0]  cnt;
      logic [ADDR_W-1:0] span;
      logic [ADDR_W-1:0] base;
      assign cnt  = cfgWord[w*CNT_W +: CNT_W];
      assign span = STEP_TAB[w] * ADDR_W'(cnt);
      assign base = REF_TAB[w] - span;
      assign winHit[w] = strobe.winOn[w] && (addr >= base) && (addr < END_TAB[w]);
    end
  endgenerate

  assign hit = strobe.checkReq && (|winHit);
endmodule

// File: rtl/dmaCutoffGuard.sv
module dmaCutoffGuard
  import dma_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [31:0] cfgWrData,
  output logic [31:0] cfgRdData,
  input  logic        reqValid,
  input  logic [31:0] reqAddr,
  output logic        reqGrant,
  output logic        reqFault
);
  logic [CFG_W-1:0] cfgWord;
  guardStrobe_t     strobe;
  logic             hit;

  guard_cfg_ctrl #(.DATA_W(32)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData),
    .rdData(cfgRdData), .reqValid(reqValid), .cfgWord(cfgWord), .strobe(strobe)
  );

  guard_addr_path u_path (
    .cfgWord(cfgWord), .strobe(strobe), .addr(reqAddr), .hit(hit)
  );

  assign reqFault = hit;
  assign reqGrant = reqValid && !hit;
endmodule

// File: rtl/dmaCutoffGuard_chk.sv
module dmaCutoffGuard_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic [31:0] cfgWrData,
  input logic [31:0] cfgRdData,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        reqGrant,
  input logic        reqFault
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $countones({reqGrant, reqFault}) == 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !reqGrant && !reqFault);

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData == {20'd0, $past(cfgWrData[11:0])});

  assert_high_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[31:12] == 20'd0);

  assert_low_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= 32'h2000_0000 && reqAddr < 32'h2080_0000) |-> reqGrant);

  assert_spill_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgRdData[3:0] != 4'd0 && reqAddr >= 32'h2800_0000 &&
     reqAddr < 32'h2880_0000) |-> reqFault);

  assert_above_main_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= 32'h3000_0000) |-> reqGrant);

  assert_cleared_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && cfgRdData == 32'd0) |-> reqGrant);
endmodule

bind dmaCutoffGuard dmaCutoffGuard_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqGrant(reqGrant), .reqFault(reqFault)
);

// File: tb/dmaCutoffGuard_tb.sv
module dmaCutoffGuard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqGrant, reqFault;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dmaCutoffGuard u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqGrant(reqGrant), .reqFault(reqFault)
  );

  function automatic bit modelFault(input logic [11:0] c, input logic [31:0] a);
    longint ad = longint'(a);
    longint xl = longint'(c[3:0]);
    longint xu = longint'(c[7:4]);
    longint xs = longint'(c[11:8]);
    bit f = 1'b0;
    if (xl != 0 && ad >= 64'h2800_0000 - 64'h80_0000 * xl && ad < 64'h3000_0000) f = 1'b1;
    if (xu != 0 && ad >= 64'h3000_0000 - 64'h80_0000 * xu && ad < 64'h3000_0000) f = 1'b1;
    if (xs != 0 && ad >= 64'h1F40_0000 - 64'h10_0000 * xs && ad < 64'h1F40_0000) f = 1'b1;
    return f;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [31:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0; cfgWrData = '0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [11:0] c);
    bit f;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    #1;
    f = modelFault(c, a);
    chk(tag, {30'd0, reqGrant, reqFault}, {30'd0, !f, f});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seedDummy;
    seedDummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset read", cfgRdData, 32'd0);
    probe("R1 reset grant", 32'h2FFF_FFFF, 12'h000);

    writeCfg(32'hFFFF_F321);
    chk("R2 readback", cfgRdData, 32'h0000_0321);
    writeCfg(32'h0000_0001);
    chk("R2 readback2", cfgRdData, 32'h0000_0001);
    probe("R3 base", 32'h2780_0000, 12'h001);
    probe("R3 below", 32'h277F_FFFF, 12'h001);
    probe("R3 spill", 32'h2800_0000, 12'h001);
    probe("R3 top", 32'h2FFF_FFFF, 12'h001);

    writeCfg(32'h0000_00F0);
    probe("R4 lower off", 32'h2800_0000, 12'h0F0);
    probe("R4 lower off2", 32'h287F_FFFF, 12'h0F0);
    probe("R6 upper15", 32'h2880_0000, 12'h0F0);

    writeCfg(32'h0000_0030);
    probe("R6 base", 32'h2E80_0000, 12'h030);
    probe("R6 below", 32'h2E7F_FFFF, 12'h030);

    writeCfg(32'h0000_0FFF);
    probe("R5 floor", 32'h207F_FFFF, 12'hFFF);
    probe("R5 floor0", 32'h2000_0000, 12'hFFF);
    probe("R3 max", 32'h2080_0000, 12'hFFF);
    probe("R10 end", 32'h3000_0000, 12'hFFF);
    probe("R10 high", 32'hFFFF_FFFF, 12'hFFF);

    writeCfg(32'h0000_0200);
    probe("R8 base", 32'h1F20_0000, 12'h200);
    probe("R8 below", 32'h1F1F_FFFF, 12'h200);
    probe("R8 end", 32'h1F40_0000, 12'h200);
    probe("R8 top", 32'h1F3F_FFFF, 12'h200);

    writeCfg(32'h0000_0051);
    probe("R7 union lo", 32'h2780_0000, 12'h051);
    probe("R7 union up", 32'h2D80_0000, 12'h051);

    @(negedge clk);
    reqValid = 1'b0; reqAddr = 32'h2FFF_FFFF;
    #1;
    chk("R9 idle", {30'd0, reqGrant, reqFault}, 32'd0);

    for (int i = 0; i < 600; i++) begin
      logic [11:0] c;
      logic [31:0] a;
      logic [31:0] edges [7];
      int sel;
      edges = '{32'h1E50_0000, 32'h1F40_0000, 32'h2000_0000, 32'h2080_0000,
                32'h2800_0000, 32'h2880_0000, 32'h3000_0000};
      if (i % 20 == 0) begin
        c = 12'($urandom);
        writeCfg({20'd0, c});
        chk("R2 random readback", cfgRdData, {20'd0, c});
      end else begin
        c = cfgRdData[11:0];
      end
      sel = int'($urandom_range(7, 0));
      if (sel == 7) a = $urandom;
      else a = edges[sel] + 32'($urandom_range(32'h120_0000, 0)) - 32'h90_0000;
      probe("R7 random", a, c);
    end

    @(negedge clk);
    reqValid = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule